// File: doc/BRIEF.md
# Multichannel Sample Serializer with Frame and Bit Clocks

This block turns one word per channel per sample period into a set of one-bit serial lanes. It has one lane for each converter channel. It runs on a fast clock at twelve times the sample rate and sends one serial bit per fast cycle, so a 12-bit word fills exactly one frame. Next to the lanes it drives a frame clock at the sample rate and a bit clock at six times the sample rate. A receiver therefore takes two data bits per bit-clock period, one on each edge.

A two-bit source selector chooses what every lane carries:

| Code | Source |
|------|--------|
| 00 | Live sample data |
| 01 | Alternating training pattern |
| 10 | Half-zero, half-one alignment pattern |
| 11 | Pattern built from three 4-bit fields |

A second input selects whether live words go out least- or most-significant bit first. A per-lane mask holds chosen lanes idle. All inputs are sampled together at a frame boundary. A change therefore never splits a word.

The block contains a small sequencer with two named states. SEQ_IDLE is held during reset. From SEQ_IDLE, on the first clock edge after reset is released, the "start" transition loads the first frame and moves to SEQ_STREAM. SEQ_STREAM counts fast cycles 0 to 11. On the "wrap" transition, taken at count 11, it stays in SEQ_STREAM, clears the count and loads the next frame.

Top module: `adc_lane_framer`

## Requirements
- R1: While rst_n is low, every lane, frame_clk and bit_clk are 0.
- R2: In streaming, frame_clk is high for fast cycles 0 to 5 of each 12-cycle frame and low for cycles 6 to 11. bit_clk is high on even cycles and low on odd cycles. It toggles every fast cycle and is high in the cycle where frame_clk rises.
- R3: With source 00 and msb_first=0, serial position k of lane i (k=0 in the cycle where frame_clk rises) carries bit k of samp_data[i*12 +: 12].
- R4: With source 00 and msb_first=1, serial position k carries bit 11-k of the lane's sample.
- R5: With source 01, every unmasked lane carries 1 at even serial positions and 0 at odd positions, starting with 1.
- R6: With source 10, every unmasked lane carries 0 at positions 0 to 5 and 1 at positions 6 to 11.
- R7: With source 11, every unmasked lane carries, in serial order, cust_a[0..3], then cust_b[0..3], then cust_c[0..3]. Pattern sources ignore samp_data and msb_first.
- R8: A lane whose pd_mask bit is 1 at the frame boundary drives 0 for that whole frame, while the other lanes are unaffected.
- R9: All inputs are captured only at the frame boundary (the edge at the end of count 11, or the first edge after reset). Changes during a frame do not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 12x the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_data | input | 96 | One 12-bit word per lane; lane i at bits [i*12 +: 12] |
| mode | input | 2 | Source select: 00 live, 01 training, 10 alignment, 11 field pattern |
| msb_first | input | 1 | 1 sends live words MSB first, 0 sends them LSB first |
| pd_mask | input | 8 | Per-lane idle mask, 1 forces the lane to 0 |
| cust_a | input | 4 | Field pattern bits for serial positions 0 to 3 |
| cust_b | input | 4 | Field pattern bits for serial positions 4 to 7 |
| cust_c | input | 4 | Field pattern bits for serial positions 8 to 11 |
| lane_out | output | 8 | Serial data, one bit per lane |
| bit_clk | output | 1 | Bit clock at 6x the sample rate |
| frame_clk | output | 1 | Frame clock at the sample rate |

## Verification
A wrong frame counter shows up within one frame. frame_clk keeps a high phase of other than six cycles or a period of other than twelve, and the lane bits drift out of line with its rising edge. A bad bit index or a swapped source shows up in the first frame after the inputs change, as a mismatch at a specific serial position. A boundary capture taken at the wrong time shows up as a mixed word in the frame during which the inputs change. The checks therefore compare every serial position of whole frames, including frames where the inputs change half-way through.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;

    typedef enum logic [1:0] {
        SRC_LIVE   = 2'b00,
        SRC_DESKEW = 2'b01,
        SRC_SYNC   = 2'b10,
        SRC_CUSTOM = 2'b11
    } src_sel_e;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_STREAM = 1'b1
    } seq_state_e;

endpackage

// File: rtl/framer_seq.sv
module framer_seq
    import adc_framer_pkg::*;
#(
    parameter int WORD_W = 12,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             running
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt;
        load    = 1'b0;
        running = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                load    = 1'b1;        // start: load first frame
                cnt_d   = '0;
                state_d = SEQ_STREAM;
            end
            SEQ_STREAM: begin
                running = 1'b1;
                load    = (cnt == LAST);  // wrap: load next frame
                cnt_d   = load ? '0 : cnt + 1'b1;
                state_d = SEQ_STREAM;
            end
        endcase
    end

endmodule

// File: rtl/framer_pattern.sv
module framer_pattern
    import adc_framer_pkg::*;
#(
    parameter int WORD_W = 12,
    localparam int NIB_W = WORD_W / 3
) (
    input  logic [1:0]        mode,
    input  logic              msb_first,
    input  logic [WORD_W-1:0] sample,
    input  logic [NIB_W-1:0]  cust_a,
    input  logic [NIB_W-1:0]  cust_b,
    input  logic [NIB_W-1:0]  cust_c,
    output logic [WORD_W-1:0] ser_word   // bit k = serial position k
);
    always_comb begin
        ser_word = '0;
        for (int k = 0; k < WORD_W; k++) begin
            unique case (mode)
                SRC_LIVE:   ser_word[k] = msb_first ? sample[WORD_W-1-k] : sample[k];
                SRC_DESKEW: ser_word[k] = (k % 2 == 0);
                SRC_SYNC:   ser_word[k] = (k >= WORD_W / 2);
                SRC_CUSTOM: ser_word[k] = 1'b0;
            endcase
        end
        if (mode == SRC_CUSTOM)
            ser_word = {cust_c, cust_b, cust_a};
    end

endmodule

// File: rtl/framer_lane.sv
module framer_lane #(
    parameter int WORD_W = 12,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              running,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [WORD_W-1:0] word_in,
    input  logic              idle_in,
    output logic              bit_out
);
    logic [WORD_W-1:0] hold_q;
    logic              idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            idle_q <= 1'b1;
        end else if (load) begin
            hold_q <= word_in;
            idle_q <= idle_in;
        end
    end

    assign bit_out = running && !idle_q && hold_q[cnt];

endmodule

// File: rtl/adc_lane_framer.sv
module adc_lane_framer #(
    parameter int LANES  = 8,
    parameter int WORD_W = 12,
    localparam int NIB_W = WORD_W / 3,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*WORD_W-1:0] samp_data,
    input  logic [1:0]              mode,
    input  logic                    msb_first,
    input  logic [LANES-1:0]        pd_mask,
    input  logic [NIB_W-1:0]        cust_a,
    input  logic [NIB_W-1:0]        cust_b,
    input  logic [NIB_W-1:0]        cust_c,
    output logic [LANES-1:0]        lane_out,
    output logic                    bit_clk,
    output logic                    frame_clk
);
    logic [CNT_W-1:0] cnt;
    logic             load;
    logic             running;

    framer_seq #(.WORD_W(WORD_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .load    (load),
        .running (running)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WORD_W-1:0] ser_word;

        framer_pattern #(.WORD_W(WORD_W)) u_pat (
            .mode      (mode),
            .msb_first (msb_first),
            .sample    (samp_data[i*WORD_W +: WORD_W]),
            .cust_a    (cust_a),
            .cust_b    (cust_b),
            .cust_c    (cust_c),
            .ser_word  (ser_word)
        );

        framer_lane #(.WORD_W(WORD_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .running (running),
            .cnt     (cnt),
            .word_in (ser_word),
            .idle_in (pd_mask[i]),
            .bit_out (lane_out[i])
        );
    end

    assign bit_clk   = running && !cnt[0];
    assign frame_clk = running && (cnt < CNT_W'(WORD_W / 2));

endmodule

// File: rtl/adc_lane_framer_chk.sv
module adc_lane_framer_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [LANES-1:0] pd_mask,
    input logic [LANES-1:0] lane_out,
    input logic             bit_clk,
    input logic             frame_clk
);
    logic [7:0] ph;
    logic       fc_q;
    logic       seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= '0;
            fc_q <= 1'b0;
            seen <= 1'b0;
        end else begin
            fc_q <= frame_clk;
            if (frame_clk && !fc_q) begin
                ph   <= 8'd1;
                seen <= 1'b1;
            end else if (ph != 8'hFF) begin
                ph <= ph + 8'd1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (lane_out == '0 && !frame_clk && !bit_clk)); // R1

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_clk && !fc_q && seen) |-> (ph == 8'd12)); // R2

    AST_FRAME_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !(frame_clk && !fc_q)) |-> (frame_clk == (ph < 8'd6))); // R2

    AST_BITCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clk |=> !bit_clk); // R2

    AST_BITCLK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_clk) |-> bit_clk); // R2

    AST_DESKEW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_clk) && $past(mode) == 2'b01) |-> (lane_out == ~$past(pd_mask))); // R5

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_clk) && $past(mode) == 2'b10) |-> (lane_out == '0)); // R6

    AST_IDLE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_clk) |-> ((lane_out & $past(pd_mask)) == '0)); // R8

endmodule

bind adc_lane_framer adc_lane_framer_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .pd_mask   (pd_mask),
    .lane_out  (lane_out),
    .bit_clk   (bit_clk),
    .frame_clk (frame_clk)
);

// File: tb/adc_lane_framer_bench.sv
module adc_lane_framer_bench;
    localparam int CLK_P = 10;
    localparam int LANES = 8;
    localparam int W     = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES*W-1:0] samp_data = '0;
    logic [1:0]       mode = 2'b00;
    logic             msb_first = 1'b0;
    logic [LANES-1:0] pd_mask = '0;
    logic [3:0]       cust_a = '0, cust_b = '0, cust_c = '0;
    logic [LANES-1:0] lane_out;
    logic             bit_clk, frame_clk;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_lane_framer u_adc_lane_framer (
        .clk(clk), .rst_n(rst_n), .samp_data(samp_data), .mode(mode),
        .msb_first(msb_first), .pd_mask(pd_mask), .cust_a(cust_a),
        .cust_b(cust_b), .cust_c(cust_c), .lane_out(lane_out),
        .bit_clk(bit_clk), .frame_clk(frame_clk)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [LANES-1:0] exp_vec(
        input logic [1:0] m, input logic msb, input logic [LANES*W-1:0] s,
        input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
        input logic [LANES-1:0] pd, input int k);
        logic [LANES-1:0] v;
        logic [11:0] fld;
        fld = {c, b, a};
        for (int i = 0; i < LANES; i++) begin
            case (m)
                2'b00: v[i] = msb ? s[i*W + (W-1-k)] : s[i*W + k];
                2'b01: v[i] = (k % 2 == 0);
                2'b10: v[i] = (k >= 6);
                default: v[i] = fld[k];
            endcase
            if (pd[i]) v[i] = 1'b0;
        end
        return v;
    endfunction

    task automatic wait_frame();
        logic prev;
        prev = frame_clk;
        forever begin
            @(negedge clk);
            if (frame_clk && !prev) break;
            prev = frame_clk;
        end
    endtask

    task automatic check_frame(input string req, input bit clocks);
        logic [1:0] m; logic msb; logic [LANES*W-1:0] s;
        logic [3:0] a, b, c; logic [LANES-1:0] pd;
        m = mode; msb = msb_first; s = samp_data; a = cust_a; b = cust_b; c = cust_c; pd = pd_mask;
        wait_frame();
        for (int k = 0; k < W; k++) begin
            if (k > 0) @(negedge clk);
            chk(32'(lane_out), 32'(exp_vec(m, msb, s, a, b, c, pd, k)), req);
            if (clocks) begin
                chk(32'(frame_clk), 32'(k < 6), "R2 frame_clk");
                chk(32'(bit_clk), 32'(k % 2 == 0), "R2 bit_clk");
            end
        end
    endtask

    function automatic logic [LANES*W-1:0] mk_samples(input logic [11:0] seed);
        logic [LANES*W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*W +: W] = seed ^ 12'(i * 12'h137);
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(32'(lane_out), 32'h0, "R1 lanes in reset");
        chk(32'(frame_clk), 32'h0, "R1 frame_clk in reset");
        chk(32'(bit_clk), 32'h0, "R1 bit_clk in reset");
    endtask

    task automatic t_live_lsb();
        mode = 2'b00; msb_first = 1'b0; samp_data = mk_samples(12'hA5C);
        check_frame("R3 live LSB-first", 1'b1);
        samp_data = mk_samples(12'h0F1);
        check_frame("R3 live LSB-first second word", 1'b1);
    endtask

    task automatic t_live_msb();
        mode = 2'b00; msb_first = 1'b1; samp_data = mk_samples(12'h3C9);
        check_frame("R4 live MSB-first", 1'b0);
        msb_first = 1'b0;
    endtask

    task automatic t_deskew();
        mode = 2'b01; msb_first = 1'b1; samp_data = mk_samples(12'hFFF);
        check_frame("R5 training pattern", 1'b0);
        msb_first = 1'b0;
    endtask

    task automatic t_sync();
        mode = 2'b10; samp_data = mk_samples(12'h555);
        check_frame("R6 alignment pattern", 1'b0);
    endtask

    task automatic t_custom();
        mode = 2'b11; cust_a = 4'h6; cust_b = 4'h9; cust_c = 4'hD; msb_first = 1'b1;
        check_frame("R7 field pattern", 1'b0);
        cust_a = 4'h1; cust_b = 4'h0; cust_c = 4'h8; msb_first = 1'b0;
        check_frame("R7 field pattern edges", 1'b0);
    endtask

    task automatic t_powerdown();
        mode = 2'b01; pd_mask = 8'b1010_0101;
        check_frame("R8 masked lanes idle (training)", 1'b0);
        mode = 2'b00; samp_data = mk_samples(12'hFFF); pd_mask = 8'b0101_1010;
        check_frame("R8 masked lanes idle (live)", 1'b0);
        pd_mask = '0;
    endtask

    task automatic t_midframe();
        logic [1:0] m; logic [LANES*W-1:0] s; logic [LANES-1:0] pd;
        mode = 2'b10; samp_data = mk_samples(12'h2B7); pd_mask = '0;
        check_frame("R9 setup frame", 1'b0);
        m = mode; s = samp_data; pd = pd_mask;
        wait_frame();
        for (int k = 0; k < W; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 4) begin
                mode = 2'b01; pd_mask = 8'hF0; samp_data = mk_samples(12'h000);
                cust_a = 4'hF;
            end
            chk(32'(lane_out), 32'(exp_vec(m, 1'b0, s, 4'h1, 4'h0, 4'h8, pd, k)),
                "R9 word unchanged mid-frame");
        end
        check_frame("R9 new inputs at next boundary", 1'b1);
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_live_lsb();
        t_live_msb();
        t_deskew();
        t_sync();
        t_custom();
        t_powerdown();
        t_midframe();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule